// File: doc/BRIEF.md
# CAN Transmit Mailbox Status Tracker

This block keeps track of three CAN transmit mailboxes and presents their state as one read-only status byte. Software or a bus engine raises a request pulse to queue a mailbox. A transmit-done or abort-done pulse retires that mailbox and raises its completion flag. Software clears a completion flag by writing 1 to it. The status byte gives three things. Each mailbox has an empty flag. Each mailbox has a lowest-priority flag, which is meaningful only while two or more mailboxes wait. A two-bit code names the mailbox that software should fill next: the first free mailbox, or the lowest-priority waiting mailbox once none is free.

Priority comes from each mailbox's identifier, and the status tracks identifier changes in the same cycle. A compatibility control turns mailbox 2 off. With mailbox 2 off, the block behaves as a two-mailbox unit. The bus engine, bus arbitration and the frame contents sit outside this block.

Top module: `can_txmb_tracker`

## Requirements
- R1: After reset with `mb2_en_i` = 0, `status_o` reads 0x0C and `cmp_flag_o` reads 0.
- R2: A `req_set_i[i]` pulse on an empty, enabled mailbox makes it pending from the next clock edge. While mailbox i is pending, its empty flag `status_o[2+i]` is 0; otherwise it is 1.
- R3: A `tx_done_i[i]` or `abort_done_i[i]` pulse clears pending for mailbox i at the next edge and sets `cmp_flag_o[i]` at the same edge.
- R4: A 1 on `cmp_clr_i[i]` clears `cmp_flag_o[i]` at the next edge, and a 0 leaves it unchanged. If a done pulse for the same mailbox arrives in the same cycle, the flag stays set.
- R5: The lowest-priority flag of mailbox i is `status_o[5+i]`. It is 1 only when at least two enabled mailboxes are pending and mailbox i ranks lowest among them. A larger `id_i` value ranks lower, and on equal identifiers the higher mailbox number ranks lower. With fewer than two mailboxes pending, all three lowest-priority flags are 0.
- R6: While any enabled mailbox is empty, `status_o[1:0]` holds the number of the lowest-numbered empty enabled mailbox.
- R7: While every enabled mailbox is pending, `status_o[1:0]` holds the number of the lowest-priority pending mailbox, ranked by the R5 rule.
- R8: With `mb2_en_i` = 0, `status_o[4]`, `status_o[7]` and `status_o[1]` read 0. A request pulse on mailbox 2 is ignored. A pending request on mailbox 2 is dropped, and it does not take part in priority.
- R9: A request pulse on a mailbox that is already pending changes no output.
- R10: Priority outputs follow `id_i` combinationally, with no register stage in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mb2_en_i | input | 1 | 1 enables mailbox 2; 0 selects compatibility mode |
| req_set_i | input | 3 | Per-mailbox transmit-request pulse |
| tx_done_i | input | 3 | Per-mailbox transmission-finished pulse |
| abort_done_i | input | 3 | Per-mailbox abort-finished pulse |
| cmp_clr_i | input | 3 | Write-1-to-clear strobe for the completion flags |
| id_i | input | 33 | Identifiers, mailbox i at bits [11*i +: 11] |
| status_o | output | 8 | {LOW flags[2:0], empty flags[2:0], code[1:0]} |
| cmp_flag_o | output | 3 | Per-mailbox request-completed flag |

## Verification
A wrong pending bit shows at the ports on the first edge after the event that caused it. It appears in the empty flag, and then in the code and the lowest-priority flags, because all of them are derived from the pending set with no extra delay. An error in the priority comparison can hide until two mailboxes wait at the same time. For that reason the stimulus fills mailboxes with distinct identifiers, with equal identifiers, and with a changing identifier, and it compares the code and the flags in every cycle. Completion-flag errors are exposed by driving a set and a clear together for one mailbox, and by writing zeros to the clear strobe.

// File: rtl/can_txmb_pkg.sv
package can_txmb_pkg;
    localparam int MB_NUM = 3;
    localparam int MB_IDW = 11;

    typedef struct packed {
        logic [MB_NUM-1:0] pend;
        logic [MB_NUM-1:0] cmp;
    } mb_state_t;
endpackage

// File: rtl/can_txmb_prio.sv
// Ranks pending mailboxes and marks the one with the lowest priority.
module can_txmb_prio #(
    parameter int NUM_MB = 3,
    parameter int ID_W   = 11,
    localparam int CW    = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic [NUM_MB-1:0]      pend_i,
    input  logic [NUM_MB*ID_W-1:0] id_i,
    output logic [NUM_MB-1:0]      low_o,
    output logic [CW-1:0]          low_idx_o
);
    logic [NUM_MB-1:0] beats_all;

    for (genvar i = 0; i < NUM_MB; i++) begin : g_rank
        logic [NUM_MB-1:0] under;
        for (genvar j = 0; j < NUM_MB; j++) begin : g_cmp
            if (i == j) begin : g_self
                assign under[j] = 1'b1;
            end else begin : g_other
                logic [ID_W-1:0] id_a;
                logic [ID_W-1:0] id_b;
                assign id_a = id_i[i*ID_W +: ID_W];
                assign id_b = id_i[j*ID_W +: ID_W];
                // mailbox i ranks below j, or j is not competing
                assign under[j] = !pend_i[j] || (id_a > id_b) ||
                                  ((id_a == id_b) && (i > j));
            end
        end
        assign beats_all[i] = pend_i[i] && (&under);
    end

    assign low_o = beats_all;

    always_comb begin
        low_idx_o = '0;
        for (int k = 0; k < NUM_MB; k++) begin
            if (beats_all[k]) low_idx_o = CW'(k);
        end
    end
endmodule

// File: rtl/can_txmb_freepick.sv
// Picks the lowest-numbered free mailbox.
module can_txmb_freepick #(
    parameter int NUM_MB = 3,
    localparam int CW    = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic [NUM_MB-1:0] free_i,
    output logic              any_o,
    output logic [CW-1:0]     idx_o
);
    always_comb begin
        idx_o = '0;
        for (int k = NUM_MB - 1; k >= 0; k--) begin
            if (free_i[k]) idx_o = CW'(k);
        end
    end
    assign any_o = |free_i;
endmodule

// File: rtl/can_txmb_tracker.sv
module can_txmb_tracker #(
    parameter int NUM_MB = can_txmb_pkg::MB_NUM,
    parameter int ID_W   = can_txmb_pkg::MB_IDW,
    localparam int CW    = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
    localparam int SW    = 2 * NUM_MB + CW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   mb2_en_i,
    input  logic [NUM_MB-1:0]      req_set_i,
    input  logic [NUM_MB-1:0]      tx_done_i,
    input  logic [NUM_MB-1:0]      abort_done_i,
    input  logic [NUM_MB-1:0]      cmp_clr_i,
    input  logic [NUM_MB*ID_W-1:0] id_i,
    output logic [SW-1:0]          status_o,
    output logic [NUM_MB-1:0]      cmp_flag_o
);
    typedef struct packed {
        logic [NUM_MB-1:0] pend;
        logic [NUM_MB-1:0] cmp;
    } trk_state_t;

    trk_state_t st_d, st_q;

    logic [NUM_MB-1:0] en_mask;
    logic [NUM_MB-1:0] eff_pend;
    logic [NUM_MB-1:0] low_raw;
    logic [CW-1:0]     low_idx;
    logic              any_free;
    logic [CW-1:0]     free_idx;
    logic              multi_pend;

    // highest mailbox is the one turned off in compatibility mode
    for (genvar i = 0; i < NUM_MB; i++) begin : g_en
        if (i == NUM_MB - 1) begin : g_top
            assign en_mask[i] = mb2_en_i;
        end else begin : g_fixed
            assign en_mask[i] = 1'b1;
        end
    end

    assign eff_pend = st_q.pend & en_mask;

    can_txmb_prio #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_prio (
        .pend_i    (eff_pend),
        .id_i      (id_i),
        .low_o     (low_raw),
        .low_idx_o (low_idx)
    );

    can_txmb_freepick #(.NUM_MB(NUM_MB)) u_free (
        .free_i (~st_q.pend & en_mask),
        .any_o  (any_free),
        .idx_o  (free_idx)
    );

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_MB; i++) begin
            if (tx_done_i[i] || abort_done_i[i]) begin
                st_d.pend[i] = 1'b0;
                st_d.cmp[i]  = 1'b1;
            end else begin
                if (req_set_i[i] && en_mask[i]) st_d.pend[i] = 1'b1;
                if (cmp_clr_i[i])               st_d.cmp[i]  = 1'b0;
            end
        end
        st_d.pend = st_d.pend & en_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign multi_pend = ($countones(eff_pend) >= 2);

    assign status_o = {low_raw & {NUM_MB{multi_pend}},
                       ~st_q.pend & en_mask,
                       any_free ? free_idx : low_idx};
    assign cmp_flag_o = st_q.cmp;
endmodule

// File: rtl/can_txmb_tracker_chk.sv
module can_txmb_tracker_chk #(
    parameter int NUM_MB = 3,
    localparam int CW    = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
    localparam int SW    = 2 * NUM_MB + CW
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mb2_en_i,
    input logic [NUM_MB-1:0] tx_done_i,
    input logic [NUM_MB-1:0] abort_done_i,
    input logic [NUM_MB-1:0] cmp_clr_i,
    input logic [SW-1:0]     status_o,
    input logic [NUM_MB-1:0] cmp_flag_o
);
    logic [NUM_MB-1:0] low_f, tme_f, en_m;
    assign low_f = status_o[CW+NUM_MB +: NUM_MB];
    assign tme_f = status_o[CW +: NUM_MB];
    assign en_m  = {mb2_en_i, {(NUM_MB-1){1'b1}}};

    a_r5_low_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(low_f));

    a_r5_low_needs_two: assert property (@(posedge clk) disable iff (!rst_n)
        (|low_f) |-> ($countones(~tme_f & en_m) >= 2));

    a_r8_compat_masks: assert property (@(posedge clk) disable iff (!rst_n)
        !mb2_en_i |-> (!tme_f[NUM_MB-1] && !low_f[NUM_MB-1] && !status_o[CW-1]));

    for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
        a_r3_done_sets_cmp: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_done_i[i] || abort_done_i[i]) |=> cmp_flag_o[i]);

        a_r3_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_done_i[i] || abort_done_i[i]) |=> (tme_f[i] || !en_m[i]));

        a_r4_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp_clr_i[i] && !tx_done_i[i] && !abort_done_i[i]) |=> !cmp_flag_o[i]);
    end
endmodule

bind can_txmb_tracker can_txmb_tracker_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mb2_en_i     (mb2_en_i),
    .tx_done_i    (tx_done_i),
    .abort_done_i (abort_done_i),
    .cmp_clr_i    (cmp_clr_i),
    .status_o     (status_o),
    .cmp_flag_o   (cmp_flag_o)
);

// File: tb/sim_can_txmb_tracker.sv
module sim_can_txmb_tracker;
    localparam int N  = 3;
    localparam int IW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mb2_en_i = 1'b0;
    logic [N-1:0]  req_set_i = '0, tx_done_i = '0, abort_done_i = '0, cmp_clr_i = '0;
    logic [N*IW-1:0] id_i = '0;
    logic [7:0]    status_o;
    logic [N-1:0]  cmp_flag_o;

    always #5 clk = ~clk;

    can_txmb_tracker u0 (.*);

    typedef struct {
        logic [7:0]   st;
        logic [N-1:0] cf;
        string        tag;
    } exp_t;

    exp_t q[$];
    int n_chk = 0, n_fail = 0;
    logic [N-1:0] m_pend = '0, m_cmp = '0;
    bit finished = 0;

    function automatic logic [7:0] model_status(logic [N-1:0] pd, logic en,
                                                logic [N*IW-1:0] ids);
        logic [N-1:0] em, p, low;
        logic [1:0] code;
        int cnt, lo;
        em = {en, 2'b11};
        p = pd & em;
        cnt = 0; lo = -1;
        for (int i = 0; i < N; i++) begin
            if (p[i]) begin
                cnt++;
                if (lo < 0 || ids[i*IW +: IW] >= ids[lo*IW +: IW]) lo = i;
            end
        end
        low = '0;
        if (cnt >= 2) low[lo] = 1'b1;
        code = 2'(lo < 0 ? 0 : lo);
        for (int i = N - 1; i >= 0; i--) if (em[i] && !pd[i]) code = 2'(i);
        return {low, ~pd & em, code};
    endfunction

    task automatic drive(input logic [N-1:0] rq, td, ad, cl, input logic en,
                         input logic [IW-1:0] i0, i1, i2, input string tag);
        @(negedge clk);
        req_set_i = rq; tx_done_i = td; abort_done_i = ad; cmp_clr_i = cl;
        mb2_en_i = en; id_i = {i2, i1, i0};
        for (int i = 0; i < N; i++) begin
            if (td[i] || ad[i]) begin
                m_pend[i] = 1'b0; m_cmp[i] = 1'b1;
            end else begin
                if (rq[i] && (i < N - 1 || en)) m_pend[i] = 1'b1;
                if (cl[i]) m_cmp[i] = 1'b0;
            end
        end
        if (!en) m_pend[N-1] = 1'b0;
        q.push_back('{model_status(m_pend, en, {i2, i1, i0}), m_cmp, tag});
    endtask

    always @(posedge clk) begin
        #3;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (status_o !== e.st || cmp_flag_o !== e.cf) begin
                n_fail++;
                $display("FAIL %s: status=%h cmp=%b expected status=%h cmp=%b",
                         e.tag, status_o, cmp_flag_o, e.st, e.cf);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #23 rst_n = 1'b1;
        #1;
        n_chk++;
        if (status_o !== 8'h0C || cmp_flag_o !== 3'b000) begin
            n_fail++;
            $display("FAIL R1: status=%h cmp=%b expected status=0c cmp=000",
                     status_o, cmp_flag_o);
        end
        drive('0, '0, '0, '0, 0, 11'd5, 11'd9, 11'd2, "R1 idle");
        drive(3'b001, '0, '0, '0, 0, 11'd5, 11'd9, 11'd2, "R2 R6 set mb0");
        drive(3'b100, '0, '0, '0, 0, 11'd5, 11'd9, 11'd2, "R8 mb2 set ignored");
        drive(3'b010, '0, '0, '0, 0, 11'd5, 11'd9, 11'd2, "R5 R7 both pending");
        drive('0, '0, '0, '0, 0, 11'd12, 11'd9, 11'd2, "R10 id swap");
        drive('0, '0, '0, '0, 0, 11'd9, 11'd9, 11'd2, "R5 R7 tie");
        drive(3'b001, '0, '0, '0, 0, 11'd9, 11'd9, 11'd2, "R9 set on pending");
        drive('0, 3'b001, '0, '0, 0, 11'd9, 11'd9, 11'd2, "R3 tx done mb0");
        drive('0, '0, 3'b010, 3'b010, 0, 11'd9, 11'd9, 11'd2, "R4 set wins");
        drive('0, '0, '0, 3'b000, 0, 11'd9, 11'd9, 11'd2, "R4 zero write");
        drive('0, '0, '0, 3'b001, 0, 11'd9, 11'd9, 11'd2, "R4 clear mb0");
        drive('0, '0, '0, '0, 1, 11'd9, 11'd9, 11'd2, "R6 mb2 enabled");
        drive(3'b110, '0, '0, '0, 1, 11'd7, 11'd3, 11'd4, "R2 R6 set mb1 mb2");
        drive(3'b001, '0, '0, '0, 1, 11'd7, 11'd3, 11'd4, "R5 R7 three pending");
        drive('0, '0, '0, '0, 1, 11'd4, 11'd3, 11'd4, "R5 R7 tie mb2");
        drive('0, '0, 3'b100, 3'b011, 1, 11'd4, 11'd3, 11'd4, "R3 R6 abort mb2");
        drive(3'b100, '0, '0, '0, 1, 11'd4, 11'd3, 11'd8, "R2 R7 refill mb2");
        drive('0, '0, '0, '0, 0, 11'd4, 11'd3, 11'd8, "R8 disable drops mb2");
        drive('0, '0, '0, '0, 1, 11'd4, 11'd3, 11'd8, "R8 re-enable empty");
        drive('0, 3'b011, '0, 3'b100, 1, 11'd4, 11'd3, 11'd8, "R3 R4 both done");
        drive('0, '0, '0, '0, 1, 11'd4, 11'd3, 11'd8, "R6 flush");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule